// File: doc/BRIEF.md
# Page-Buffered Serial Memory Write Commit

This block sits behind the byte-level decoder of a two-wire serial memory slave. When a write transaction begins it captures the base word address, then collects every received data byte into a small page latch with a per-byte valid mask. The column part of the address advances after each byte and wraps inside the page, while the upper address bits stay where the transaction put them. Nothing reaches the storage array until the transaction closes with a STOP.

On a qualifying STOP, a commit engine walks the page latch one column per clock and drives the array write port for each received byte. It then holds a busy flag through a programmable number of clocks that stands in for the internal program time. The address of the last byte received goes back to the slave's address counter as a one-cycle report. An abort (a repeated START), a write-protect input that is high at STOP, and a STOP with no data bytes each end the transaction without any programming. The array is a plain behavioural memory with a combinational read port for the read path.

Top module: `eepw_page_commit`

## Requirements
- R1: After reset, `busy`, `arr_we` and `last_addr_vld` are low.
- R2: A write transaction (`wr_start` with base address, one `byte_vld`, then `stop_evt` with `wp_pin` low) leaves the byte at the base address once `busy` has fallen.
- R3: Address bits 3:0 form the page column and advance by one after each byte, wrapping from 15 to 0. Bits 10:4 stay as given by the base address, so a page starting at column 14 writes columns 14, 15, 0, ...
- R4: Bytes beyond the sixteenth of one transaction wrap the column and replace bytes loaded earlier in the same page. Only the latest value per column is programmed.
- R5: Only columns that received a byte are programmed. Every other location of the page keeps its previous contents.
- R6: `abort_evt`, or a new `wr_start`, before the STOP discards all latched bytes. A later STOP then programs nothing and does not raise `busy`.
- R7: If `wp_pin` is high when the STOP is taken, no location at any address is written and `busy` stays low.
- R8: A STOP with no data byte received since `wr_start` raises neither `busy` nor `last_addr_vld`.
- R9: After a committing STOP, `busy` rises in the next cycle and stays high for exactly 16 + `WR_CYCLES` clocks. While it is high, `wr_start`, `byte_vld`, `stop_evt` and `abort_evt` are ignored.
- R10: A STOP that follows at least one data byte gives a one-cycle `last_addr_vld` pulse in the next cycle. `last_addr` carries the address of the last byte received, not that address plus one, and is reported whether or not `wp_pin` is high.
- R11: During a commit, `arr_we` pulses exactly once for each distinct column received, with `arr_waddr` = {bits 10:4 of the page, column} and `arr_wdata` the byte held for that column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | One-cycle pulse opening a write transaction |
| wr_base_addr | input | 11 | Word address given by the transaction |
| byte_vld | input | 1 | One-cycle strobe of a received data byte |
| byte_data | input | 8 | Data byte qualified by `byte_vld` |
| stop_evt | input | 1 | One-cycle pulse for a STOP on the bus |
| abort_evt | input | 1 | One-cycle pulse for a repeated START |
| wp_pin | input | 1 | Write-protect level, high blocks all writes |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Array read data, combinational |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit and internal program time in progress |
| last_addr | output | 11 | Final address for the slave address counter |
| last_addr_vld | output | 1 | One-cycle qualifier of `last_addr` |

## Verification
The assertions assume that `wr_start`, `byte_vld`, `stop_evt` and `abort_evt` are single-cycle pulses, that no more than one of them is high in the same cycle, and that `wp_pin` is steady around a STOP. The bench drives each event as a one-cycle pulse on the falling clock edge, never overlaps two events, and changes `wp_pin` only between transactions. Event pulses during `busy` are injected on purpose, since the block must ignore them.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_PROG = 2'd1,
    ENG_WAIT = 2'd2
  } eng_state_e;

endpackage

// File: rtl/eepw_array.sv
module eepw_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/eepw_page_latch.sv
module eepw_page_latch #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     freeze,
  input  logic                     wr_start,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic                     byte_vld,
  input  logic [DATA_W-1:0]        byte_data,
  input  logic                     stop_evt,
  input  logic                     abort_evt,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_col,
  output logic [DATA_W-1:0]        rd_byte,
  output logic [PAGE_BYTES-1:0]    valid_mask,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_upper,
  output logic [$clog2(PAGE_BYTES)-1:0] last_col,
  output logic                     is_open,
  output logic                     has_data
);
  localparam int COL_W   = $clog2(PAGE_BYTES);
  localparam int UPPER_W = ADDR_W - COL_W;

  logic               open_q, open_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [COL_W-1:0]   last_q, last_d;
  logic [UPPER_W-1:0] upper_q, upper_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic               byte_take;
  logic [DATA_W-1:0]  data_q [PAGE_BYTES];

  // Event priority: start, abort, stop, byte. Everything is frozen during a commit.
  assign byte_take = !freeze && !wr_start && !abort_evt && !stop_evt && byte_vld && open_q;

  always_comb begin
    open_d  = open_q;
    col_d   = col_q;
    last_d  = last_q;
    upper_d = upper_q;
    mask_d  = mask_q;
    if (!freeze) begin
      if (wr_start) begin
        open_d  = 1'b1;
        col_d   = base_addr[COL_W-1:0];
        upper_d = base_addr[ADDR_W-1:COL_W];
        mask_d  = '0;
      end else if (abort_evt) begin
        open_d = 1'b0;
        mask_d = '0;
      end else if (stop_evt) begin
        open_d = 1'b0;
      end else if (byte_take) begin
        mask_d[col_q] = 1'b1;
        last_d        = col_q;
        col_d         = col_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      col_q   <= '0;
      last_q  <= '0;
      upper_q <= '0;
      mask_q  <= '0;
    end else begin
      open_q  <= open_d;
      col_q   <= col_d;
      last_q  <= last_d;
      upper_q <= upper_d;
      mask_q  <= mask_d;
    end
  end

  for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_col
    logic col_en;
    assign col_en = byte_take && (col_q == COL_W'(gi));
    always_ff @(posedge clk) begin
      if (col_en) begin
        data_q[gi] <= byte_data;
      end
    end
  end

  assign rd_byte    = data_q[rd_col];
  assign valid_mask = mask_q;
  assign page_upper = upper_q;
  assign last_col   = last_q;
  assign is_open    = open_q;
  assign has_data   = |mask_q;

  // R6: an accepted abort leaves no latched byte behind
  p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !freeze && !wr_start) |=> !has_data);

  // R5: an accepted byte is marked as received
  p_take_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> has_data);

  // R3: upper address bits stay fixed while a transaction is open
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !wr_start) |=> $stable(upper_q));

  // R9: nothing in the latch moves during a commit
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(mask_q));

endmodule

// File: rtl/eepw_commit_engine.sv
module eepw_commit_engine
  import eepw_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_req,
  input  logic [PAGE_BYTES-1:0]         valid_mask,
  output logic [$clog2(PAGE_BYTES)-1:0] scan_col,
  output logic                          scan_we,
  output logic                          busy
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int LEN_W = $clog2(PAGE_BYTES + WR_CYCLES + 2);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  eng_state_e       state_q, state_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (commit_req) begin
          state_d = ENG_PROG;
          idx_d   = '0;
        end
      end
      ENG_PROG: begin
        if (idx_q == LAST_COL) begin
          state_d = ENG_WAIT;
          cnt_d   = CNT_W'(WR_CYCLES - 1);
        end else begin
          idx_d = idx_q + COL_W'(1);
        end
      end
      ENG_WAIT: begin
        if (cnt_q == '0) begin
          state_d = ENG_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scan_col = idx_q;
  assign scan_we  = (state_q == ENG_PROG) && valid_mask[idx_q];
  assign busy     = (state_q != ENG_IDLE);

  // Checker: length of each busy window
  logic [LEN_W-1:0] blen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
    end else if (busy) begin
      blen_q <= blen_q + LEN_W'(1);
    end else begin
      blen_q <= '0;
    end
  end

  // R9: busy covers the scan and the program time exactly
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == LEN_W'(PAGE_BYTES + WR_CYCLES)));

  // R2: busy only starts from a commit request
  p_busy_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_req));

endmodule

// File: rtl/eepw_page_commit.sv
module eepw_page_commit #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_base_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              abort_evt,
  input  logic              wp_pin,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic              last_addr_vld
);
  localparam int COL_W   = $clog2(PAGE_BYTES);
  localparam int UPPER_W = ADDR_W - COL_W;

  logic [COL_W-1:0]      scan_col;
  logic                  scan_we;
  logic [DATA_W-1:0]     scan_byte;
  logic [PAGE_BYTES-1:0] valid_mask;
  logic [UPPER_W-1:0]    page_upper;
  logic [COL_W-1:0]      last_col;
  logic                  is_open;
  logic                  has_data;
  logic                  stop_ok;
  logic                  commit_req;
  logic                  eng_busy;

  eepw_page_latch #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (eng_busy),
    .wr_start  (wr_start),
    .base_addr (wr_base_addr),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .stop_evt  (stop_evt),
    .abort_evt (abort_evt),
    .rd_col    (scan_col),
    .rd_byte   (scan_byte),
    .valid_mask(valid_mask),
    .page_upper(page_upper),
    .last_col  (last_col),
    .is_open   (is_open),
    .has_data  (has_data)
  );

  // A STOP counts only with an open transaction holding data and no commit running
  assign stop_ok    = stop_evt && !wr_start && !abort_evt && is_open && has_data && !eng_busy;
  assign commit_req = stop_ok && !wp_pin;

  eepw_commit_engine #(
    .PAGE_BYTES(PAGE_BYTES),
    .WR_CYCLES (WR_CYCLES)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_req(commit_req),
    .valid_mask(valid_mask),
    .scan_col  (scan_col),
    .scan_we   (scan_we),
    .busy      (eng_busy)
  );

  assign arr_we    = scan_we;
  assign arr_waddr = {page_upper, scan_col};
  assign arr_wdata = scan_byte;
  assign busy      = eng_busy;

  eepw_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk  (clk),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(arr_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  logic [ADDR_W-1:0] last_q, last_d;
  logic              lvld_q;

  always_comb begin
    last_d = last_q;
    if (stop_ok) begin
      last_d = {page_upper, last_col};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      lvld_q <= 1'b0;
    end else begin
      last_q <= last_d;
      lvld_q <= stop_ok;
    end
  end

  assign last_addr     = last_q;
  assign last_addr_vld = lvld_q;

  // R7: a protected STOP starts no program time
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wp_pin && !busy) |=> !busy);

  // R8: an empty STOP neither programs nor reports
  p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !busy && !has_data) |=> (!busy && !last_addr_vld));

  // R10: the address report only follows a STOP
  p_report_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_addr_vld |-> $past(stop_evt));

  // R11: the write port is only active inside a busy window
  p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

endmodule

// File: tb/eepw_page_commit_test.sv
module eepw_page_commit_test;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int PB = 16;
  localparam int WRC = 40;
  localparam int NVEC = 8;

  // Vector fields: [25] wp, [24:19] byte count, [18:11] data seed, [10:0] base address
  localparam logic [31:0] VEC [NVEC] = '{
    {6'd0, 1'b0, 6'd1,  8'h5A, 11'h100},  // R2 single byte
    {6'd0, 1'b0, 6'd3,  8'h10, 11'h1FE},  // R3 column wrap
    {6'd0, 1'b0, 6'd16, 8'h80, 11'h230},  // full page
    {6'd0, 1'b0, 6'd3,  8'hC0, 11'h234},  // R5 partial page
    {6'd0, 1'b0, 6'd18, 8'h20, 11'h300},  // R4 overwrite after wrap
    {6'd0, 1'b1, 6'd5,  8'hEE, 11'h230},  // R7 protected
    {6'd0, 1'b0, 6'd2,  8'h33, 11'h7FF},  // R3 top page wrap
    {6'd0, 1'b0, 6'd0,  8'h00, 11'h400}   // R8 empty
  };

  logic clk = 1'b0;
  logic rst_n;
  logic wr_start, byte_vld, stop_evt, abort_evt, wp_pin;
  logic [AW-1:0] wr_base_addr, rd_addr;
  logic [DW-1:0] byte_data, rd_data, arr_wdata;
  logic [AW-1:0] arr_waddr, last_addr;
  logic arr_we, busy, last_addr_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] shadow [1 << AW];
  bit            known  [1 << AW];

  always #5 clk = ~clk;

  eepw_page_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_base_addr(wr_base_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .abort_evt(abort_evt),
    .wp_pin(wp_pin), .rd_addr(rd_addr), .rd_data(rd_data), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .busy(busy), .last_addr(last_addr),
    .last_addr_vld(last_addr_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ev_start(input logic [AW-1:0] a);
    @(negedge clk); wr_start = 1'b1; wr_base_addr = a;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic ev_byte(input logic [DW-1:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic ev_abort();
    @(negedge clk); abort_evt = 1'b1;
    @(negedge clk); abort_evt = 1'b0;
  endtask

  // STOP, then check the report and measure busy and write pulses
  task automatic ev_stop(input bit exp_vld, input logic [AW-1:0] exp_addr,
                         input int exp_busy, input int exp_we, input string req);
    int blen = 0;
    int wen = 0;
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    chk(last_addr_vld == exp_vld, {req, " R10 report valid"}, int'(last_addr_vld), int'(exp_vld));
    if (exp_vld) chk(last_addr == exp_addr, {req, " R10 last address"}, int'(last_addr), int'(exp_addr));
    for (int k = 0; k < 400; k++) begin
      if (!busy) break;
      blen++;
      if (arr_we) wen++;
      @(negedge clk);
    end
    if (exp_busy == 0) begin
      repeat (3) begin
        if (busy) blen++;
        @(negedge clk);
      end
    end
    chk(blen == exp_busy, {req, " R9 busy length"}, blen, exp_busy);
    chk(wen == exp_we, {req, " R11 write pulses"}, wen, exp_we);
  endtask

  task automatic check_page(input logic [AW-1:0] a, input string req);
    for (int c = 0; c < PB; c++) begin
      logic [AW-1:0] ad;
      ad = {a[AW-1:4], 4'(c)};
      if (known[ad]) begin
        rd_addr = ad;
        #1;
        chk(rd_data == shadow[ad], req, int'(rd_data), int'(shadow[ad]));
      end
    end
  endtask

  task automatic run_vec(input logic [31:0] v, input string req);
    logic [AW-1:0] base;
    logic [DW-1:0] seed;
    int n;
    bit wp;
    int distinct;
    logic [AW-1:0] la;
    base = v[10:0]; seed = v[18:11]; n = int'(v[24:19]); wp = v[25];
    wp_pin = wp;
    ev_start(base);
    for (int i = 0; i < n; i++) ev_byte(seed + DW'(i));
    distinct = (n > PB) ? PB : n;
    la = {base[AW-1:4], 4'(int'(base[3:0]) + n - 1)};
    ev_stop(n > 0, la, (n == 0 || wp) ? 0 : PB + WRC, (n == 0 || wp) ? 0 : distinct, req);
    if (n > 0 && !wp) begin
      for (int i = 0; i < n; i++) begin
        logic [AW-1:0] ad;
        ad = {base[AW-1:4], 4'(int'(base[3:0]) + i)};
        shadow[ad] = seed + DW'(i);
        known[ad] = 1'b1;
      end
    end
    check_page(base, {req, " memory"});
    wp_pin = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) known[i] = 1'b0;
    rst_n = 1'b0; wr_start = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0; abort_evt = 1'b0;
    wp_pin = 1'b0; wr_base_addr = '0; byte_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
    chk(last_addr_vld == 1'b0, "R1 report", int'(last_addr_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      case (v)
        0: tag = "R2"; 1: tag = "R3"; 2: tag = "R11"; 3: tag = "R5";
        4: tag = "R4"; 5: tag = "R7"; 6: tag = "R3"; default: tag = "R8";
      endcase
      run_vec(VEC[v], tag);
    end

    // R6 abort discards latched bytes
    ev_start(11'h230);
    ev_byte(8'hA1); ev_byte(8'hA2); ev_byte(8'hA3);
    ev_abort();
    ev_stop(1'b0, '0, 0, 0, "R6 abort");
    check_page(11'h230, "R6 page unchanged after abort");

    // R6 a fresh start also discards bytes
    ev_start(11'h300);
    ev_byte(8'h77);
    ev_start(11'h305);
    ev_stop(1'b0, '0, 0, 0, "R6 restart");
    check_page(11'h300, "R6 page unchanged after restart");

    // R9 events during busy are ignored
    ev_start(11'h108);
    ev_byte(8'h4C);
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    shadow[11'h108] = 8'h4C; known[11'h108] = 1'b1;
    ev_start(11'h100);
    ev_byte(8'hFF);
    ev_byte(8'hFE);
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    chk(last_addr_vld == 1'b0, "R9 stop ignored while busy", int'(last_addr_vld), 0);
    for (int k = 0; k < 400; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 no second commit", int'(busy), 0);
    check_page(11'h100, "R9 memory untouched by ignored events");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule